// File: doc/BRIEF.md
# Configurable Microcontroller Bus Interface

This block connects the external bus of a microcontroller to the internal functional blocks of a programmable peripheral. A lower byte port and an upper byte port carry the address. In the multiplexed style the lower byte port also carries the data. In the non-multiplexed style data moves over a dedicated data port instead. While an address strobe is high the address is captured, and the captured address is handed to internal decode logic together with a read strobe, a write strobe, a code-fetch flag, a generic forwarded input and the write data.

The meaning of the three control inputs is chosen at reset from four styles:

| Style | Encoding | Control input 0 | Control input 1 |
|---|---|---|---|
| split strobes | 0 | active-low write | active-low read |
| select plus E clock | 1 | read/write select, high = read | E clock |
| select plus data strobe | 2 | read/write select, high = read | active-low data strobe |
| program-select read | 3 | active-low write | active-low program-select read |

Separately, control input 2 may be set up as an active-low program-select line. Read data is driven back onto the bus only while a read is active and an internal block reports itself selected. The bus style and the control style are held in a configuration register that loads only while the active-low reset is held.

A small state machine tracks the bus cycle. Its states are ST_IDLE, ST_ADDR, ST_READ and ST_WRITE, and its transitions are:

| From | To | Condition |
|---|---|---|
| ST_IDLE | ST_ADDR | address strobe high in multiplexed style |
| ST_IDLE | ST_READ | otherwise, read active |
| ST_IDLE | ST_WRITE | otherwise, write active |
| ST_ADDR | ST_IDLE | strobe low |
| ST_READ | ST_IDLE | read inactive |
| ST_WRITE | ST_IDLE | write inactive; this transition also emits the write strobe |

Top module: `mcu_bus_bridge`

## Requirements
- R1: In the multiplexed style (cfg_muxed=1), `addr` takes {bus_hi_in, bus_lo_in} at every clock edge where `ale` is high and holds otherwise. In the non-multiplexed style (cfg_muxed=0), `ale` is ignored and `addr` follows {bus_hi_in, bus_lo_in} one clock later.
- R2: The read drive enable is high only while `rd_stb` is high and `blk_sel` is high, and it follows them combinationally. The drive goes to `bus_lo_out`/`bus_lo_oe` in the multiplexed style and to `data_out`/`data_oe` in the non-multiplexed style. The other enable stays low, and the driven value is `rd_data`.
- R3: Style 0 (split strobes): ctl0 low indicates a write and ctl1 low indicates a read.
- R4: Style 1 (select plus E clock): a read is ctl0=1 with ctl1=1, and a write is ctl0=0 with ctl1=1. With ctl1=0 there is no access.
- R5: Style 2 (select plus data strobe): a read is ctl0=1 with ctl1=0, and a write is ctl0=0 with ctl1=0. With ctl1=1 there is no access.
- R6: Style 3 (program-select read): ctl1 low is a read with `code_fetch`=1, and ctl0 low is a write.
- R7: With cfg_pe=1, ctl2 low is an additional read with `code_fetch`=1, and `gen_in` is 0. With cfg_pe=0, `gen_in` equals ctl2 and ctl2 has no effect on `rd_stb` or `code_fetch`.
- R8: When a write indication ends, `wr_stb` is high for exactly one cycle after the first clock edge that sees it inactive. At that point `wr_data` holds the data sampled at the last edge where the write was active: from `bus_lo_in` when multiplexed and from `data_in` when not.
- R9: A read indication takes priority. While a read is active, no write is recognised and no write strobe follows.
- R10: cfg_muxed, cfg_style and cfg_pe are captured only while rst_n is low. Changes to them while rst_n is high have no effect.
- R11: While rst_n is low, both drive enables, `rd_stb` and `code_fetch` are low. `addr`, `wr_data` and `wr_stb` clear to 0 at the first clock edge in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | block clock |
| rst_n | input | 1 | active-low reset; must be held at power-up |
| cfg_muxed | input | 1 | 1 = multiplexed bus style (loaded in reset) |
| cfg_style | input | 2 | control style 0..3 (loaded in reset) |
| cfg_pe | input | 1 | 1 = ctl2 is an active-low program-select (loaded in reset) |
| ale | input | 1 | address strobe, active high |
| ctl0 | input | 1 | control input 0 |
| ctl1 | input | 1 | control input 1 |
| ctl2 | input | 1 | control input 2 |
| bus_lo_in | input | DATA_W | lower byte port, pin value |
| bus_lo_out | output | DATA_W | lower byte port, driven value |
| bus_lo_oe | output | 1 | lower byte port drive enable (0 = high-impedance) |
| bus_hi_in | input | ADDR_W-DATA_W | upper byte port, pin value |
| data_in | input | DATA_W | dedicated data port, pin value |
| data_out | output | DATA_W | dedicated data port, driven value |
| data_oe | output | 1 | dedicated data port drive enable (0 = high-impedance) |
| addr | output | ADDR_W | captured address to internal decode |
| rd_stb | output | 1 | read active |
| wr_stb | output | 1 | one-cycle write strobe |
| code_fetch | output | 1 | current read is a program-select read |
| gen_in | output | 1 | ctl2 forwarded as a generic input |
| wr_data | output | DATA_W | captured write data |
| rd_data | input | DATA_W | read data from internal blocks |
| blk_sel | input | 1 | an internal block is selected |

## Verification
A wrong read decode shows at once on `rd_stb`, `code_fetch` and the drive enables, because they are combinational in the pins. A state machine stuck outside ST_WRITE shows as a missing `wr_stb` one cycle after the write ends. A stale hold register shows on `wr_data` in that same cycle. A latch that captures at the wrong time shows on `addr` one clock after the strobe falls, once the lower byte port changes to data. A configuration register that loads outside reset shows as a changed `rd_stb` for the same pins in the very next cycle.

// File: rtl/mbb_pkg.sv
package mbb_pkg;

    typedef enum logic [1:0] {
        CTL_SPLIT = 2'd0,
        CTL_RWE   = 2'd1,
        CTL_RWDS  = 2'd2,
        CTL_PSEL  = 2'd3
    } ctl_style_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_READ,
        ST_WRITE
    } bus_st_e;

    typedef struct packed {
        logic       muxed;
        logic       pe;
        ctl_style_e style;
    } bus_cfg_t;

endpackage

// File: rtl/mbb_cfg_reg.sv
module mbb_cfg_reg
    import mbb_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  bus_cfg_t cfg_d,
    output bus_cfg_t cfg_q
);
    // loads only while reset is held; frozen afterwards
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= cfg_d;
        end
    end
endmodule

// File: rtl/mbb_ctl_decode.sv
module mbb_ctl_decode
    import mbb_pkg::*;
(
    input  bus_cfg_t cfg,
    input  logic     ctl0,
    input  logic     ctl1,
    input  logic     ctl2,
    output logic     rd_act,
    output logic     wr_act,
    output logic     code_fetch,
    output logic     gen_in
);
    logic rd_style;
    logic wr_style;
    logic cf_style;
    logic pe_rd;

    always_comb begin
        rd_style = 1'b0;
        wr_style = 1'b0;
        cf_style = 1'b0;
        unique case (cfg.style)
            CTL_SPLIT: begin
                rd_style = !ctl1;
                wr_style = !ctl0;
            end
            CTL_RWE: begin
                rd_style = ctl0 && ctl1;
                wr_style = !ctl0 && ctl1;
            end
            CTL_RWDS: begin
                rd_style = ctl0 && !ctl1;
                wr_style = !ctl0 && !ctl1;
            end
            CTL_PSEL: begin
                rd_style = !ctl1;
                cf_style = !ctl1;
                wr_style = !ctl0;
            end
        endcase
    end

    assign pe_rd      = cfg.pe && !ctl2;
    assign rd_act     = rd_style || pe_rd;
    assign wr_act     = wr_style && !rd_act;
    assign code_fetch = cf_style || pe_rd;
    assign gen_in     = cfg.pe ? 1'b0 : ctl2;
endmodule

// File: rtl/mbb_addr_latch.sv
module mbb_addr_latch #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    localparam int HI_W  = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              muxed,
    input  logic              ale,
    input  logic [DATA_W-1:0] lo,
    input  logic [HI_W-1:0]   hi,
    output logic [ADDR_W-1:0] addr
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (!muxed || ale) begin
            addr <= {hi, lo};
        end
    end
endmodule

// File: rtl/mbb_bus_fsm.sv
module mbb_bus_fsm
    import mbb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              muxed,
    input  logic              ale,
    input  logic              rd_act,
    input  logic              wr_act,
    input  logic [DATA_W-1:0] wdata_src,
    output logic              wr_stb,
    output logic [DATA_W-1:0] wr_data
);
    bus_st_e           state;
    bus_st_e           state_nx;
    logic [DATA_W-1:0] hold;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (muxed && ale) begin
                    state_nx = ST_ADDR;
                end else if (rd_act) begin
                    state_nx = ST_READ;
                end else if (wr_act) begin
                    state_nx = ST_WRITE;
                end
            end
            ST_ADDR:  if (!ale)    state_nx = ST_IDLE;
            ST_READ:  if (!rd_act) state_nx = ST_IDLE;
            ST_WRITE: if (!wr_act) state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold    <= '0;
            wr_data <= '0;
            wr_stb  <= 1'b0;
        end else begin
            wr_stb <= 1'b0;
            if (wr_act) begin
                hold <= wdata_src;
            end
            if (state == ST_WRITE && !wr_act) begin
                wr_data <= hold;
                wr_stb  <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/mcu_bus_bridge.sv
module mcu_bus_bridge
    import mbb_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    localparam int HI_W  = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_muxed,
    input  logic [1:0]        cfg_style,
    input  logic              cfg_pe,
    input  logic              ale,
    input  logic              ctl0,
    input  logic              ctl1,
    input  logic              ctl2,
    input  logic [DATA_W-1:0] bus_lo_in,
    output logic [DATA_W-1:0] bus_lo_out,
    output logic              bus_lo_oe,
    input  logic [HI_W-1:0]   bus_hi_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic [ADDR_W-1:0] addr,
    output logic              rd_stb,
    output logic              wr_stb,
    output logic              code_fetch,
    output logic              gen_in,
    output logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              blk_sel
);
    bus_cfg_t          cfg_d;
    bus_cfg_t          cfg_q;
    logic              cfg_muxed_w;
    logic              rd_act;
    logic              wr_act;
    logic              cf_raw;
    logic              drive;
    logic [DATA_W-1:0] wdata_src;

    assign cfg_d = '{muxed: cfg_muxed, pe: cfg_pe, style: ctl_style_e'(cfg_style)};
    assign cfg_muxed_w = cfg_q.muxed;

    mbb_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .cfg_d (cfg_d),
        .cfg_q (cfg_q)
    );

    mbb_ctl_decode u_dec (
        .cfg        (cfg_q),
        .ctl0       (ctl0),
        .ctl1       (ctl1),
        .ctl2       (ctl2),
        .rd_act     (rd_act),
        .wr_act     (wr_act),
        .code_fetch (cf_raw),
        .gen_in     (gen_in)
    );

    mbb_addr_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_lat (
        .clk   (clk),
        .rst_n (rst_n),
        .muxed (cfg_muxed_w),
        .ale   (ale),
        .lo    (bus_lo_in),
        .hi    (bus_hi_in),
        .addr  (addr)
    );

    assign wdata_src = cfg_muxed_w ? bus_lo_in : data_in;

    mbb_bus_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .muxed     (cfg_muxed_w),
        .ale       (ale),
        .rd_act    (rd_act),
        .wr_act    (wr_act),
        .wdata_src (wdata_src),
        .wr_stb    (wr_stb),
        .wr_data   (wr_data)
    );

    assign rd_stb     = rst_n && rd_act;
    assign code_fetch = rst_n && cf_raw;
    assign drive      = rd_stb && blk_sel;
    assign bus_lo_oe  = drive && cfg_muxed_w;
    assign data_oe    = drive && !cfg_muxed_w;
    assign bus_lo_out = rd_data;
    assign data_out   = rd_data;
endmodule

// File: rtl/mbb_bus_checker.sv
module mbb_bus_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_muxed,
    input logic              ale,
    input logic              blk_sel,
    input logic              rd_stb,
    input logic              bus_lo_oe,
    input logic              data_oe,
    input logic              wr_stb,
    input logic [ADDR_W-1:0] addr
);
    // R2: a drive enable needs both an active read and a selected block
    a_r2_oe_needs_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_lo_oe || data_oe) |-> (rd_stb && blk_sel));

    // R2: never both ports at once
    a_r2_one_port: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_lo_oe && data_oe));

    // R8: the write strobe lasts a single cycle
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    // R1: multiplexed address holds when the strobe was low
    a_r1_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_muxed && !$past(ale)) |-> $stable(addr));

    // R11: nothing is driven while reset is held
    a_r11_quiet_in_reset: assert property (@(posedge clk)
        !rst_n |-> (!bus_lo_oe && !data_oe && !rd_stb));
endmodule

bind mcu_bus_bridge mbb_bus_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_muxed (cfg_muxed_w),
    .ale       (ale),
    .blk_sel   (blk_sel),
    .rd_stb    (rd_stb),
    .bus_lo_oe (bus_lo_oe),
    .data_oe   (data_oe),
    .wr_stb    (wr_stb),
    .addr      (addr)
);

// File: tb/test_mcu_bus_bridge.sv
module test_mcu_bus_bridge;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_muxed;
    logic [1:0]  cfg_style;
    logic        cfg_pe;
    logic        ale, ctl0, ctl1, ctl2;
    logic [7:0]  bus_lo_in, bus_hi_in, data_in, rd_data;
    logic        blk_sel;
    logic [7:0]  bus_lo_out, data_out, wr_data;
    logic        bus_lo_oe, data_oe, rd_stb, wr_stb, code_fetch, gen_in;
    logic [15:0] addr;

    int n_run = 0;
    int n_fail = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    mcu_bus_bridge i_mcu_bus_bridge (
        .clk(clk), .rst_n(rst_n), .cfg_muxed(cfg_muxed), .cfg_style(cfg_style),
        .cfg_pe(cfg_pe), .ale(ale), .ctl0(ctl0), .ctl1(ctl1), .ctl2(ctl2),
        .bus_lo_in(bus_lo_in), .bus_lo_out(bus_lo_out), .bus_lo_oe(bus_lo_oe),
        .bus_hi_in(bus_hi_in), .data_in(data_in), .data_out(data_out),
        .data_oe(data_oe), .addr(addr), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .code_fetch(code_fetch), .gen_in(gen_in), .wr_data(wr_data),
        .rd_data(rd_data), .blk_sel(blk_sel)
    );

    // vector: [9:8] style [7] pe [6] ctl0 [5] ctl1 [4] ctl2 | [3] rd [2] wr [1] cf [0] gen
    localparam int NV = 17;
    localparam logic [9:0] VEC [NV] = '{
        10'b00_0_101_1001,  // R3 read
        10'b00_0_011_0101,  // R3 write
        10'b00_0_000_1000,  // R9 both low
        10'b00_0_111_0001,  // R3 none
        10'b01_0_111_1001,  // R4 read
        10'b01_0_011_0101,  // R4 write
        10'b01_0_101_0001,  // R4 E low
        10'b01_0_001_0001,  // R4 E low
        10'b10_0_101_1001,  // R5 read
        10'b10_0_001_0101,  // R5 write
        10'b10_0_011_0001,  // R5 strobe high
        10'b11_0_101_1011,  // R6 program read
        10'b11_0_011_0101,  // R6 write
        10'b00_1_110_1010,  // R7 ctl2 read
        10'b00_1_111_0000,  // R7 none
        10'b00_1_010_1010,  // R9 with ctl2 read
        10'b01_1_100_1010   // R7 in E style
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input logic [9:0] v);
        if (v[3] && !v[6]) return "R9";
        if (v[7]) return "R7";
        case (v[9:8])
            2'd0: return "R3";
            2'd1: return "R4";
            2'd2: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic set_idle(input logic [1:0] st);
        ctl0 = 1'b1;
        ctl1 = (st == 2'd1) ? 1'b0 : 1'b1;
        ctl2 = 1'b1;
    endtask

    task automatic do_reset(input logic mx, input logic [1:0] st, input logic pe);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_muxed = mx; cfg_style = st; cfg_pe = pe;
        ale = 1'b0;
        set_idle(st);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        while (cycles < 20000) begin
            @(posedge clk);
            cycles++;
        end
        n_fail++;
        $display("FAIL watchdog: actual %0d expected below 20000", cycles);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [2:0] cur_cfg;
        rst_n = 1'b0; cfg_muxed = 1'b1; cfg_style = 2'd0; cfg_pe = 1'b0;
        ale = 1'b0; ctl0 = 1'b1; ctl1 = 1'b1; ctl2 = 1'b1;
        bus_lo_in = 8'h00; bus_hi_in = 8'h00; data_in = 8'h00;
        rd_data = 8'h00; blk_sel = 1'b0;

        // R11: reset state
        do_reset(1'b1, 2'd0, 1'b0);
        cur_cfg = 3'b000;
        check("R11", "addr after reset", 32'(addr), 32'h0);
        check("R11", "wr_stb after reset", 32'(wr_stb), 32'h0);
        check("R11", "wr_data after reset", 32'(wr_data), 32'h0);

        // table walk, multiplexed style
        for (int i = 0; i < NV; i++) begin
            logic [9:0] v;
            v = VEC[i];
            if ({v[9:8], v[7]} != cur_cfg) begin
                do_reset(1'b1, v[9:8], v[7]);
                cur_cfg = {v[9:8], v[7]};
            end
            ctl0 = v[6]; ctl1 = v[5]; ctl2 = v[4];
            bus_lo_in = 8'h30 + 8'(i);
            #1;
            check(req_of(v), "rd_stb", 32'(rd_stb), 32'(v[3]));
            check(req_of(v), "code_fetch", 32'(code_fetch), 32'(v[1]));
            check(req_of(v), "gen_in", 32'(gen_in), 32'(v[0]));
            repeat (2) @(negedge clk);
            set_idle(v[9:8]);
            bus_lo_in = 8'hEE;
            @(negedge clk);
            check(req_of(v), "wr_stb after end", 32'(wr_stb), 32'(v[2]));
            if (v[2]) check("R8", "wr_data", 32'(wr_data), 32'(8'h30 + 8'(i)));
            @(negedge clk);
            check("R8", "wr_stb one cycle", 32'(wr_stb), 32'h0);
        end

        // R1: multiplexed address latch
        do_reset(1'b1, 2'd0, 1'b0);
        ale = 1'b1; bus_hi_in = 8'h12; bus_lo_in = 8'h34;
        @(negedge clk);
        ale = 1'b0; bus_lo_in = 8'h56; bus_hi_in = 8'h99;
        repeat (2) @(negedge clk);
        check("R1", "muxed addr held", 32'(addr), 32'h1234);

        // R8: one-cycle write in multiplexed style
        ctl0 = 1'b0; bus_lo_in = 8'hC3;
        @(negedge clk);
        ctl0 = 1'b1; bus_lo_in = 8'h00;
        @(negedge clk);
        check("R8", "short write strobe", 32'(wr_stb), 32'h1);
        check("R8", "short write data", 32'(wr_data), 32'hC3);

        // R2: multiplexed read drive
        rd_data = 8'h6D; blk_sel = 1'b1; ctl1 = 1'b0;
        #1;
        check("R2", "lo oe", 32'(bus_lo_oe), 32'h1);
        check("R2", "lo out", 32'(bus_lo_out), 32'h6D);
        check("R2", "data oe muxed", 32'(data_oe), 32'h0);
        blk_sel = 1'b0;
        #1;
        check("R2", "lo oe no sel", 32'(bus_lo_oe), 32'h0);
        blk_sel = 1'b1; ctl1 = 1'b1;
        #1;
        check("R2", "lo oe no read", 32'(bus_lo_oe), 32'h0);

        // R10: config inputs ignored outside reset
        @(negedge clk);
        cfg_style = 2'd1; cfg_muxed = 1'b0;
        ctl0 = 1'b1; ctl1 = 1'b0;
        @(negedge clk);
        check("R10", "style unchanged", 32'(rd_stb), 32'h1);
        check("R10", "muxed unchanged", 32'(bus_lo_oe), 32'h1);
        ctl1 = 1'b1;
        @(negedge clk);

        // R1: non-multiplexed follow, ale ignored
        do_reset(1'b0, 2'd0, 1'b0);
        bus_hi_in = 8'hCD; bus_lo_in = 8'hAB; ale = 1'b0;
        @(negedge clk);
        check("R1", "non-muxed addr", 32'(addr), 32'hCDAB);

        // R8: non-multiplexed write takes data port
        ctl0 = 1'b0; data_in = 8'h5A; bus_lo_in = 8'hA5;
        repeat (2) @(negedge clk);
        ctl0 = 1'b1;
        @(negedge clk);
        check("R8", "non-muxed wr_stb", 32'(wr_stb), 32'h1);
        check("R8", "non-muxed wr_data", 32'(wr_data), 32'h5A);

        // R2: non-multiplexed read drive
        rd_data = 8'h77; blk_sel = 1'b1; ctl1 = 1'b0;
        #1;
        check("R2", "data oe", 32'(data_oe), 32'h1);
        check("R2", "data out", 32'(data_out), 32'h77);
        check("R2", "lo oe non-muxed", 32'(bus_lo_oe), 32'h0);
        blk_sel = 1'b0;
        #1;
        check("R2", "data oe no sel", 32'(data_oe), 32'h0);

        // R11: reset forces quiet outputs and clears state
        blk_sel = 1'b1;
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R11", "oe in reset", 32'(data_oe), 32'h0);
        check("R11", "rd_stb in reset", 32'(rd_stb), 32'h0);
        @(negedge clk);
        check("R11", "addr cleared", 32'(addr), 32'h0);
        check("R11", "wr_data cleared", 32'(wr_data), 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule